// File: doc/BRIEF.md
# Trace Timestamp Request Generator

This block sits beside an instrumentation trace unit. It holds one 32-bit control word, keeps a local timestamp counter, and decides when the trace unit should insert a global timestamp. The local counter advances on a reference tick that is first divided by a ratio chosen by a 2-bit code. The counter can be held at zero while the trace output line is idle.

The global side watches a 48-bit global count and raises a one-cycle request. Depending on the frequency code, the request fires when a chosen upper slice of the count moves, or after each emitted packet that leaves the output FIFO empty. The block also exports the packet-forwarding enable and the 7-bit trace source identifier held in the control word. Packet formatting, the FIFO and any clock crossing belong to the surrounding logic.

Top module: `tstamp_ctrl`

## Requirements
- R1: After synchronous reset the control read-back, `fwd_en`, `bus_id`, `lcl_count` and `ts_req` are all zero.
- R2: A cycle with `cfg_wr_en` high stores all 32 bits of `cfg_wr_data`, and from the next cycle `cfg_rd_data` returns them. The fields are: forward enable at bit 3 (driven on `fwd_en`), clock select at bit 4, prescale code at bits 9:8, frequency code at bits 11:10, and source identifier at bits 22:16 (driven on `bus_id`).
- R3: The prescale code selects how many `ref_tick` cycles make one local count: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 64. The count increments in the cycle after the tick that completes the ratio.
- R4: A write whose prescale code differs from the stored one clears the divider progress, and any tick in that cycle is discarded. A write that keeps the same code leaves the divider progress unchanged.
- R5: While clock select is 1 and `line_idle` is 1, the local count and divider are cleared in the next cycle. With clock select 0, `line_idle` has no effect.
- R6: With frequency code 0, `ts_req` never rises.
- R7: With frequency code 1, `ts_req` is high for one cycle, in the cycle after any cycle in which bits 47:7 of `glb_count` differ from their value in the previous cycle. A change confined to bits 6:0 raises nothing.
- R8: With frequency code 2, the same rule applies to bits 47:13. A change confined to bits 12:0 raises nothing.
- R9: With frequency code 3, `ts_req` is high in the cycle after a cycle with `pkt_sent` and `fifo_empty` both high. A `pkt_sent` with `fifo_empty` low raises nothing.
- R10: The local count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| ref_tick | input | 1 | Reference tick feeding the prescaler |
| glb_count | input | GLB_W (48) | Global timestamp count |
| pkt_sent | input | 1 | A trace packet was emitted this cycle |
| fifo_empty | input | 1 | Output FIFO is empty |
| line_idle | input | 1 | Trace output line is idle |
| cfg_rd_data | output | 32 | Control word read-back |
| ts_req | output | 1 | Global timestamp request pulse |
| lcl_count | output | LCL_W (16) | Local timestamp count |
| fwd_en | output | 1 | Hardware event forwarding enable |
| bus_id | output | 7 | Trace source identifier |

## Verification
The bench builds the block with an 8-bit local counter and leaves the global width and both watch thresholds at their defaults. With an 8-bit counter, wraparound is reached after a few hundred ticks. Because the bench drives the 48-bit global count directly, it can place edits just below and just at bit 7 and bit 13 without waiting for those bits to roll over.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int CTL_W     = 32;
  localparam int FWD_BIT   = 3;
  localparam int CSEL_BIT  = 4;
  localparam int PSC_LO    = 8;
  localparam int FRQ_LO    = 10;
  localparam int BID_LO    = 16;
  localparam int BID_W     = 7;
  localparam int DIV_W     = 6;

  typedef enum logic [1:0] {
    GTS_OFF    = 2'b00,
    GTS_FINE   = 2'b01,
    GTS_COARSE = 2'b10,
    GTS_PKT    = 2'b11
  } gts_mode_e;

  // ticks per local count: 4 to the power of the code
  function automatic logic [DIV_W:0] psc_ratio(input logic [1:0] code);
    return (DIV_W+1)'(1) << {code, 1'b0};
  endfunction
endpackage

// File: rtl/tstamp_ctl_reg.sv
module tstamp_ctl_reg
  import tstamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_q,
  output logic             fwd_en,
  output logic             clk_sel,
  output logic [1:0]       psc,
  output gts_mode_e        mode,
  output logic [BID_W-1:0] bus_id,
  output logic             psc_restart
);
  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  assign fwd_en      = ctl_q[FWD_BIT];
  assign clk_sel     = ctl_q[CSEL_BIT];
  assign psc         = ctl_q[PSC_LO +: 2];
  assign mode        = gts_mode_e'(ctl_q[FRQ_LO +: 2]);
  assign bus_id      = ctl_q[BID_LO +: BID_W];
  assign psc_restart = wr_en && (wr_data[PSC_LO +: 2] != ctl_q[PSC_LO +: 2]);

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctl_q == $past(wr_data)));
endmodule

// File: rtl/tstamp_local.sv
module tstamp_local
  import tstamp_pkg::*;
#(
  parameter int LCL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       psc,
  input  logic             clk_sel,
  input  logic             line_idle,
  input  logic             restart,
  output logic [LCL_W-1:0] lcl_cnt,
  output logic             adv
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   ratio;
  logic             hold;

  assign ratio = psc_ratio(psc);
  assign hold  = clk_sel && line_idle;
  assign adv   = !hold && !restart && tick && (div_q == DIV_W'(ratio - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      div_q   <= '0;
      lcl_cnt <= '0;
    end else if (restart) begin
      div_q   <= '0;
    end else if (tick) begin
      if (adv) begin
        div_q   <= '0;
        lcl_cnt <= lcl_cnt + 1'b1;
      end else begin
        div_q   <= div_q + 1'b1;
      end
    end
  end

  // R5
  hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (lcl_cnt == '0));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (lcl_cnt != $past(lcl_cnt)) |-> (lcl_cnt == LCL_W'($past(lcl_cnt) + 1'b1) || lcl_cnt == '0));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !hold) |=> (div_q == '0 && $stable(lcl_cnt)));
endmodule

// File: rtl/tstamp_greq.sv
module tstamp_greq
  import tstamp_pkg::*;
#(
  parameter int GLB_W     = 48,
  parameter int FINE_LO   = 7,
  parameter int COARSE_LO = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  gts_mode_e              mode,
  input  logic [GLB_W-1:FINE_LO] gcnt_hi,
  input  logic                   pkt_sent,
  input  logic                   fifo_empty,
  output logic                   ts_req
);
  logic [GLB_W-1:FINE_LO] prev_q;
  logic                   chg_fine, chg_coarse, pkt_hit, hit;

  assign chg_fine   = gcnt_hi != prev_q;
  assign chg_coarse = gcnt_hi[GLB_W-1:COARSE_LO] != prev_q[GLB_W-1:COARSE_LO];
  assign pkt_hit    = pkt_sent && fifo_empty;

  always_comb begin
    case (mode)
      GTS_FINE:   hit = chg_fine;
      GTS_COARSE: hit = chg_coarse;
      GTS_PKT:    hit = pkt_hit;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      ts_req <= 1'b0;
    end else begin
      prev_q <= gcnt_hi;
      ts_req <= hit;
    end
  end

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ts_req |-> ($past(mode) != GTS_OFF));
  // R9
  pkt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_req && $past(mode) == GTS_PKT) |-> $past(pkt_sent && fifo_empty));
  // R7
  fine_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == GTS_FINE && chg_fine) |=> ts_req);
  // R8
  coarse_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == GTS_COARSE && chg_coarse) |=> ts_req);
endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int GLB_W     = 48,
  parameter int LCL_W     = 16,
  parameter int FINE_LO   = 7,
  parameter int COARSE_LO = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [31:0]      cfg_wr_data,
  input  logic             ref_tick,
  input  logic [GLB_W-1:0] glb_count,
  input  logic             pkt_sent,
  input  logic             fifo_empty,
  input  logic             line_idle,
  output logic [31:0]      cfg_rd_data,
  output logic             ts_req,
  output logic [LCL_W-1:0] lcl_count,
  output logic             fwd_en,
  output logic [6:0]       bus_id
);
  logic       clk_sel, psc_restart, lcl_adv;
  logic [1:0] psc;
  gts_mode_e  mode;
  logic       unused_low_bits;

  assign unused_low_bits = ^{glb_count[FINE_LO-1:0], lcl_adv};

  tstamp_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .ctl_q(cfg_rd_data), .fwd_en(fwd_en), .clk_sel(clk_sel), .psc(psc),
    .mode(mode), .bus_id(bus_id), .psc_restart(psc_restart)
  );

  tstamp_local #(.LCL_W(LCL_W)) u_local (
    .clk(clk), .rst(rst), .tick(ref_tick), .psc(psc), .clk_sel(clk_sel),
    .line_idle(line_idle), .restart(psc_restart), .lcl_cnt(lcl_count), .adv(lcl_adv)
  );

  tstamp_greq #(.GLB_W(GLB_W), .FINE_LO(FINE_LO), .COARSE_LO(COARSE_LO)) u_greq (
    .clk(clk), .rst(rst), .mode(mode), .gcnt_hi(glb_count[GLB_W-1:FINE_LO]),
    .pkt_sent(pkt_sent), .fifo_empty(fifo_empty), .ts_req(ts_req)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ts_req && lcl_count == '0 && cfg_rd_data == '0));
endmodule

// File: tb/tstamp_ctrl_test.sv
module tstamp_ctrl_test;
  localparam int LW = 8;

  logic        clk = 0, rst = 1;
  logic        cfg_wr_en = 0;
  logic [31:0] cfg_wr_data = 0;
  logic        ref_tick = 0, pkt_sent = 0, fifo_empty = 0, line_idle = 0;
  logic [47:0] glb_count = 0;
  logic [31:0] cfg_rd_data;
  logic        ts_req, fwd_en;
  logic [LW-1:0] lcl_count;
  logic [6:0]  bus_id;

  int total = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctl;
  int          m_div, m_loc;
  bit          m_req;
  longint      m_prev;
  string       m_req_tag = "R6";

  always #2.5 clk = ~clk;

  tstamp_ctrl #(.LCL_W(LW)) uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .ref_tick(ref_tick), .glb_count(glb_count), .pkt_sent(pkt_sent),
    .fifo_empty(fifo_empty), .line_idle(line_idle), .cfg_rd_data(cfg_rd_data),
    .ts_req(ts_req), .lcl_count(lcl_count), .fwd_en(fwd_en), .bus_id(bus_id)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0; m_div = 0; m_loc = 0; m_req = 0; m_prev = 0;
    end else begin
      int     ratio;
      int     code;
      longint g;
      g = longint'(glb_count);
      code = m_ctl[11:10];
      case (code)
        1: begin m_req = (g >> 7) != (m_prev >> 7);   m_req_tag = "R7"; end
        2: begin m_req = (g >> 13) != (m_prev >> 13); m_req_tag = "R8"; end
        3: begin m_req = pkt_sent && fifo_empty;      m_req_tag = "R9"; end
        default: begin m_req = 0;                     m_req_tag = "R6"; end
      endcase
      m_prev = g;
      ratio = 1;
      repeat (m_ctl[9:8]) ratio = ratio * 4;
      if (m_ctl[4] && line_idle) begin
        m_loc = 0; m_div = 0;
      end else if (cfg_wr_en && cfg_wr_data[9:8] != m_ctl[9:8]) begin
        m_div = 0;
      end else if (ref_tick) begin
        m_div++;
        if (m_div == ratio) begin
          m_div = 0;
          m_loc = (m_loc + 1) % (1 << LW);
        end
      end
      if (cfg_wr_en) m_ctl = cfg_wr_data;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_req_tag, ts_req, m_req);
      chk("R3 local count", lcl_count, m_loc);
      chk("R2 read-back", cfg_rd_data, m_ctl);
      chk("R2 fwd_en", fwd_en, m_ctl[3]);
      chk("R2 bus_id", bus_id, m_ctl[22:16]);
    end
  end

  task automatic wr(input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin ref_tick = 1; @(negedge clk); end
    ref_tick = 0;
  endtask

  initial begin
    glb_count = 48'hABCD_0000_1234;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rd", cfg_rd_data, 0); chk("R1 fwd", fwd_en, 0);
    chk("R1 bus", bus_id, 0); chk("R1 lcl", lcl_count, 0); chk("R1 req", ts_req, 0);

    // R3 ratios
    ticks(5);             chk("R3 div1", lcl_count, 5);
    wr(32'h100); ticks(8); chk("R3 div4", lcl_count, 7);
    // R4 same code keeps progress, new code restarts
    ticks(3); wr(32'h100); ticks(1); chk("R4 same code", lcl_count, 8);
    ticks(2); wr(32'h200); ticks(15); chk("R4 restart", lcl_count, 8);
    ticks(1);             chk("R3 div16", lcl_count, 9);
    wr(32'h300); ticks(63); chk("R3 div64 early", lcl_count, 9);
    ticks(1);             chk("R3 div64", lcl_count, 10);

    // R5 idle hold
    wr(32'h10); line_idle = 1; @(negedge clk); chk("R5 hold", lcl_count, 0);
    line_idle = 0; ticks(3); chk("R5 release", lcl_count, 3);
    wr(32'h0); line_idle = 1; ticks(2); chk("R5 ignored", lcl_count, 5);
    line_idle = 0;

    // R10 wrap
    ticks(255); chk("R10 wrap", lcl_count, 4);

    // R2 fields
    wr(32'h005A_0008);
    chk("R2 rd", cfg_rd_data, 32'h005A_0008); chk("R2 fwd", fwd_en, 1); chk("R2 bus", bus_id, 7'h5A);

    // R6 off
    glb_count = 48'h0; @(negedge clk); chk("R6 off", ts_req, 0);

    // R7 fine slice
    wr(32'h400); glb_count = 48'h100; @(negedge clk); @(negedge clk);
    glb_count = 48'h140; @(negedge clk); chk("R7 low bits", ts_req, 0);
    glb_count = 48'h180; @(negedge clk); chk("R7 bit7", ts_req, 1);
    @(negedge clk); chk("R7 one cycle", ts_req, 0);
    for (int i = 0; i < 400; i++) begin glb_count = glb_count + 37; @(negedge clk); end

    // R8 coarse slice
    wr(32'h800); glb_count = 48'h2000; @(negedge clk); @(negedge clk);
    glb_count = 48'h3F80; @(negedge clk); chk("R8 below 13", ts_req, 0);
    glb_count = 48'h4000; @(negedge clk); chk("R8 bit13", ts_req, 1);
    for (int i = 0; i < 300; i++) begin glb_count = glb_count + 1000; @(negedge clk); end

    // R9 packet mode
    wr(32'hC00);
    pkt_sent = 1; fifo_empty = 0; @(negedge clk); pkt_sent = 0; chk("R9 fifo busy", ts_req, 0);
    @(negedge clk);
    pkt_sent = 1; fifo_empty = 1; @(negedge clk); pkt_sent = 0; chk("R9 fifo empty", ts_req, 1);
    for (int i = 0; i < 200; i++) begin
      pkt_sent = (i % 3) != 0; fifo_empty = (i % 2) == 0; glb_count = glb_count + 500;
      @(negedge clk);
    end
    pkt_sent = 0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule